// File: doc/BRIEF.md
# Packed 12-bit Symbol Error Corrector

This block writes Reed-Solomon corrections back into a page buffer. Other logic finds the errors and hands over up to four pairs, each a symbol position and a 12-bit error pattern. The buffer is byte-wide and linear. A 2048-byte data area sits at addresses 0 to 2047, and the out-of-band (OOB) area follows from address 2048 upward. Code symbols are 12 bits wide and are packed across byte boundaries, so most symbols touch two bytes. The symbol at position 0 is a partial one of 8 bits.

A `start` pulse captures the pairs and a pair count. The block then works through the pairs one at a time, in input order. For each byte a pair touches, it reads the byte in one cycle and writes back the byte XOR a mask in the next cycle. A pair it cannot use is skipped and leaves the buffer alone. At the end the block gives a one-cycle `done` pulse, together with the number of corrections applied and a flag that is set when any pair was rejected. Computing the syndromes and searching for the error locations are not part of this block.

Top module: `fec_sym_fixer`

## Requirements
- R1: Position 0 updates only byte 0, which is XORed with pattern bits 7:0. A pattern above 0xFF at position 0 is rejected.
- R2: An odd position p from 1 to 1374 XORs byte floor(3p/2) with pattern bits 11:4. It then XORs the next byte with {pattern bits 3:0, 4'b0000}.
- R3: An even position p from 2 to 1374 XORs byte 3p/2-1 with {4'b0000, pattern bits 11:8}. It then XORs byte 3p/2 with pattern bits 7:0.
- R4: Position 1365 changes data byte 2047 (XOR pattern bits 11:4) and OOB byte 0, which is buffer address 2048 (XOR {pattern bits 3:0, 4'b0000}). OOB byte k is always at buffer address 2048+k.
- R5: Positions 1366 to 1374 follow the odd/even rules of R2 and R3 and land in the OOB area. Any position above 1374 is rejected.
- R6: Each byte update asserts `mem_rd` for one cycle, then asserts `mem_wr` in the next cycle at the same address. The written value is the byte that was read XOR the mask. `mem_rd` and `mem_wr` are never high in the same cycle.
- R7: Only the first min(`pair_cnt`, 4) pairs are used, in input order. Pairs beyond that count leave the buffer untouched. A count of 0 finishes at once without any buffer access.
- R8: `done` is high for exactly one cycle. At that time `fix_count` equals the number of pairs applied and `uncorrectable` is 1 if any pair was rejected. A rejected pair writes nothing, and the other pairs in the same batch are still applied.
- R9: `busy` is high from the cycle after an accepted `start` through the `done` cycle. A `start` that arrives while `busy` is high is ignored.
- R10: After reset, `busy`, `done`, `fix_count` and `uncorrectable` are 0, and there is no buffer access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a batch; sampled only while idle |
| pair_cnt | input | 3 | Number of pairs to apply (clamped to 4) |
| pos_in | input | 44 | Pair positions, pair i at bits [11i+10:11i] |
| pat_in | input | 48 | Pair error patterns, pair i at bits [12i+11:12i] |
| busy | output | 1 | Batch in progress |
| done | output | 1 | One-cycle end-of-batch pulse |
| fix_count | output | 3 | Pairs applied in the last batch |
| uncorrectable | output | 1 | A pair in the last batch was rejected |
| mem_addr | output | 12 | Buffer byte address |
| mem_rd | output | 1 | Buffer read strobe; data is returned one cycle later |
| mem_rdata | input | 8 | Buffer read data |
| mem_wr | output | 1 | Buffer write strobe |
| mem_wdata | output | 8 | Buffer write data |

## Verification
The hardest case to reach from the ports is a batch that mixes rejected and accepted pairs. The rejected pair must write nothing, and the accepted pairs after it must still land. The bench builds such a batch from an out-of-range position, a good data position and a position far past the limit. It then compares the whole buffer model byte by byte. A second hard case is two pairs that hit the same symbol. That case only checks out if each read sees the previous write, so the bench repeats a position within one batch. Finally, the bench raises `start` again in the middle of a batch to show that the second request is dropped.

// File: rtl/fec_sym_pkg.sv
package fec_sym_pkg;
  localparam int SYM_W  = 12;
  localparam int BYTE_W = 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SEL,
    ST_RD,
    ST_WR,
    ST_FIN
  } rmw_state_t;
endpackage

// File: rtl/fec_sym_map.sv
module fec_sym_map
  import fec_sym_pkg::*;
#(
  parameter int POS_W    = 11,
  parameter int ADDR_W   = 12,
  parameter int LAST_POS = 1374
) (
  input  logic [POS_W-1:0]  pos,
  input  logic [SYM_W-1:0]  pat,
  output logic              ok,
  output logic              single,
  output logic [ADDR_W-1:0] addr0,
  output logic [BYTE_W-1:0] mask0,
  output logic [BYTE_W-1:0] mask1
);
  localparam int TW = POS_W + 2;

  // first byte a packed symbol touches
  function automatic logic [TW-1:0] lead_byte(input logic [POS_W-1:0] p);
    logic [TW-1:0] half;
    half = (TW'(p) * TW'(3)) >> 1;
    return p[0] ? half : half - TW'(1);
  endfunction

  function automatic logic [BYTE_W-1:0] first_mask(input logic odd, input logic [SYM_W-1:0] v);
    return odd ? v[11:4] : {4'h0, v[11:8]};
  endfunction

  function automatic logic [BYTE_W-1:0] second_mask(input logic odd, input logic [SYM_W-1:0] v);
    return odd ? {v[3:0], 4'h0} : v[7:0];
  endfunction

  logic [TW-1:0] lead;
  assign lead = lead_byte(pos);

  always_comb begin
    ok     = 1'b1;
    single = 1'b0;
    addr0  = lead[ADDR_W-1:0];
    mask0  = first_mask(pos[0], pat);
    mask1  = second_mask(pos[0], pat);
    if (pos == '0) begin
      single = 1'b1;
      addr0  = '0;
      mask0  = pat[7:0];
      mask1  = '0;
      ok     = (pat[11:8] == 4'h0);
    end else if (pos > POS_W'(LAST_POS)) begin
      ok = 1'b0;
    end
  end
endmodule

// File: rtl/fec_pair_sel.sv
module fec_pair_sel
  import fec_sym_pkg::*;
#(
  parameter int N     = 4,
  parameter int POS_W = 11,
  parameter int IDX_W = 3
) (
  input  logic [N*POS_W-1:0] pos_vec,
  input  logic [N*SYM_W-1:0] pat_vec,
  input  logic [IDX_W-1:0]   idx,
  output logic [POS_W-1:0]   pos,
  output logic [SYM_W-1:0]   pat
);
  logic [POS_W-1:0] pos_a [N];
  logic [SYM_W-1:0] pat_a [N];

  for (genvar g = 0; g < N; g++) begin : g_split
    assign pos_a[g] = pos_vec[g*POS_W +: POS_W];
    assign pat_a[g] = pat_vec[g*SYM_W +: SYM_W];
  end

  always_comb begin
    pos = '0;
    pat = '0;
    for (int i = 0; i < N; i++) begin
      if (idx == IDX_W'(i)) begin
        pos = pos_a[i];
        pat = pat_a[i];
      end
    end
  end
endmodule

// File: rtl/fec_sym_fixer.sv
module fec_sym_fixer
  import fec_sym_pkg::*;
#(
  parameter int NUM_PAIRS = 4,
  parameter int POS_W     = 11,
  parameter int ADDR_W    = 12,
  parameter int LAST_POS  = 1374,
  localparam int IDX_W    = $clog2(NUM_PAIRS + 1)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       start,
  input  logic [IDX_W-1:0]           pair_cnt,
  input  logic [NUM_PAIRS*POS_W-1:0] pos_in,
  input  logic [NUM_PAIRS*SYM_W-1:0] pat_in,
  output logic                       busy,
  output logic                       done,
  output logic [IDX_W-1:0]           fix_count,
  output logic                       uncorrectable,
  output logic [ADDR_W-1:0]          mem_addr,
  output logic                       mem_rd,
  input  logic [BYTE_W-1:0]          mem_rdata,
  output logic                       mem_wr,
  output logic [BYTE_W-1:0]          mem_wdata
);
  localparam int ADDR_LIMIT = (3 * LAST_POS) / 2 + 1;

  rmw_state_t                 st;
  logic [IDX_W-1:0]           idx, lim_q, fix_q;
  logic                       second, err_q;
  logic [NUM_PAIRS*POS_W-1:0] pos_q;
  logic [NUM_PAIRS*SYM_W-1:0] pat_q;

  // named internal events
  logic [POS_W-1:0]  cur_pos;
  logic [SYM_W-1:0]  cur_pat;
  logic              cur_ok, cur_single;
  logic [ADDR_W-1:0] cur_addr0;
  logic [BYTE_W-1:0] cur_mask0, cur_mask1;
  logic              batch_end, pair_reject, pair_applied;

  fec_pair_sel #(.N(NUM_PAIRS), .POS_W(POS_W), .IDX_W(IDX_W)) u_sel (
    .pos_vec(pos_q), .pat_vec(pat_q), .idx(idx), .pos(cur_pos), .pat(cur_pat)
  );

  fec_sym_map #(.POS_W(POS_W), .ADDR_W(ADDR_W), .LAST_POS(LAST_POS)) u_map (
    .pos(cur_pos), .pat(cur_pat), .ok(cur_ok), .single(cur_single),
    .addr0(cur_addr0), .mask0(cur_mask0), .mask1(cur_mask1)
  );

  assign batch_end    = (st == ST_SEL) && (idx == lim_q);
  assign pair_reject  = (st == ST_SEL) && (idx != lim_q) && !cur_ok;
  assign pair_applied = (st == ST_WR) && (second || cur_single);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= ST_IDLE;
      idx    <= '0;
      lim_q  <= '0;
      fix_q  <= '0;
      err_q  <= 1'b0;
      second <= 1'b0;
      pos_q  <= '0;
      pat_q  <= '0;
    end else begin
      case (st)
        ST_IDLE: if (start) begin
          pos_q  <= pos_in;
          pat_q  <= pat_in;
          lim_q  <= (pair_cnt > IDX_W'(NUM_PAIRS)) ? IDX_W'(NUM_PAIRS) : pair_cnt;
          idx    <= '0;
          fix_q  <= '0;
          err_q  <= 1'b0;
          second <= 1'b0;
          st     <= ST_SEL;
        end
        ST_SEL: begin
          if (batch_end) st <= ST_FIN;
          else if (pair_reject) begin
            err_q <= 1'b1;
            idx   <= idx + 1'b1;
          end else begin
            second <= 1'b0;
            st     <= ST_RD;
          end
        end
        ST_RD: st <= ST_WR;
        ST_WR: begin
          if (pair_applied) begin
            second <= 1'b0;
            fix_q  <= fix_q + 1'b1;
            idx    <= idx + 1'b1;
            st     <= ST_SEL;
          end else begin
            second <= 1'b1;
            st     <= ST_RD;
          end
        end
        ST_FIN:  st <= ST_IDLE;
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign busy          = (st != ST_IDLE);
  assign done          = (st == ST_FIN);
  assign fix_count     = fix_q;
  assign uncorrectable = err_q;
  assign mem_rd        = (st == ST_RD);
  assign mem_wr        = (st == ST_WR);
  assign mem_addr      = second ? cur_addr0 + 1'b1 : cur_addr0;
  assign mem_wdata     = mem_rdata ^ (second ? cur_mask1 : cur_mask0);

  // R6: read and write strobes exclusive
  p_rdwr_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd && mem_wr));

  // R6: every write follows a read of the same byte
  p_wr_after_rd_r6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr |-> ($past(mem_rd) && mem_addr == $past(mem_addr)));

  // R8: done is a single-cycle pulse
  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R8: applied count never exceeds the clamped pair count
  p_count_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (fix_count <= lim_q));

  // R5: accesses stay inside the area that legal positions reach
  p_addr_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd || mem_wr) |-> (32'(mem_addr) <= ADDR_LIMIT));

  // R10: idle block leaves the buffer alone
  p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!mem_rd && !mem_wr));

  // R9: a batch cannot restart before it reports done
  p_no_restart_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done) |=> busy);
endmodule

// File: tb/fec_sym_fixer_tb.sv
module fec_sym_fixer_tb;
  localparam int NV = 12;
  localparam int MEMSZ = 4096;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [2:0]  pair_cnt = '0;
  logic [43:0] pos_in = '0;
  logic [47:0] pat_in = '0;
  logic        busy, done, uncorrectable, mem_rd, mem_wr;
  logic [2:0]  fix_count;
  logic [11:0] mem_addr;
  logic [7:0]  mem_rdata, mem_wdata;

  always #5 clk = ~clk;

  fec_sym_fixer u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .pair_cnt(pair_cnt),
    .pos_in(pos_in), .pat_in(pat_in), .busy(busy), .done(done),
    .fix_count(fix_count), .uncorrectable(uncorrectable),
    .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_rdata(mem_rdata),
    .mem_wr(mem_wr), .mem_wdata(mem_wdata)
  );

  logic [7:0] ram   [MEMSZ];
  logic [7:0] exp_m [MEMSZ];
  int errors = 0, checks = 0, proto_bad = 0, touches = 0;
  logic prev_rd = 1'b0;
  logic [11:0] prev_addr = '0;

  always @(posedge clk) begin
    if (mem_rd) mem_rdata <= ram[mem_addr];
    if (mem_wr) ram[mem_addr] <= mem_wdata;
  end

  // R6 protocol monitor, sampled away from the edge
  always @(negedge clk) begin
    if (mem_rd || mem_wr) touches++;
    if (mem_rd && mem_wr) proto_bad++;
    if (mem_wr && !(prev_rd && prev_addr == mem_addr)) proto_bad++;
    prev_rd   = mem_rd;
    prev_addr = mem_addr;
  end

  // vectors: cnt, positions {p3,p2,p1,p0}, patterns, expected count, expected flag
  localparam logic [2:0] V_CNT [NV] = '{3'd1, 3'd1, 3'd1, 3'd1, 3'd1, 3'd2,
                                        3'd3, 3'd4, 3'd2, 3'd0, 3'd7, 3'd2};
  localparam logic [43:0] V_POS [NV] = '{
    {11'd0, 11'd0, 11'd0, 11'd0},          // R1 position 0 ok
    {11'd0, 11'd0, 11'd0, 11'd0},          // R1 position 0 rejected
    {11'd0, 11'd0, 11'd0, 11'd5},          // R2 odd
    {11'd0, 11'd0, 11'd0, 11'd6},          // R3 even
    {11'd0, 11'd0, 11'd0, 11'd1365},       // R4 straddle
    {11'd0, 11'd0, 11'd1374, 11'd1367},    // R5 OOB area
    {11'd0, 11'd2047, 11'd10, 11'd1375},   // R5 R8 mixed rejects
    {11'd1365, 11'd3, 11'd2, 11'd1},       // R7 four pairs
    {11'd8, 11'd7, 11'd200, 11'd100},      // R7 extra pairs unused
    {11'd0, 11'd0, 11'd0, 11'd11},         // R7 zero count
    {11'd15, 11'd14, 11'd13, 11'd12},      // R7 clamp
    {11'd0, 11'd0, 11'd9, 11'd9}           // R7 same symbol twice
  };
  localparam logic [47:0] V_PAT [NV] = '{
    {12'h0, 12'h0, 12'h0, 12'h0A5},
    {12'h0, 12'h0, 12'h0, 12'h1A5},
    {12'h0, 12'h0, 12'h0, 12'hABC},
    {12'h0, 12'h0, 12'h0, 12'h123},
    {12'h0, 12'h0, 12'h0, 12'hFED},
    {12'h0, 12'h0, 12'h777, 12'h3C5},
    {12'h0, 12'hFFF, 12'h800, 12'h001},
    {12'h111, 12'h9A9, 12'h00F, 12'h0F0},
    {12'hFFF, 12'hFFF, 12'h789, 12'h456},
    {12'h0, 12'h0, 12'h0, 12'hFFF},
    {12'h404, 12'h303, 12'h202, 12'h101},
    {12'h0, 12'h0, 12'h222, 12'h111}
  };
  localparam logic [2:0] V_EC [NV] = '{3'd1, 3'd0, 3'd1, 3'd1, 3'd1, 3'd2,
                                       3'd1, 3'd4, 3'd2, 3'd0, 3'd4, 3'd2};
  localparam logic V_EE [NV] = '{1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0,
                                 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0};

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  // independent model written with separate data and OOB arrays in mind
  task automatic model_pair(input int p, input int pat);
    int b;
    if (p == 0) begin
      if (pat <= 255) exp_m[0] ^= 8'(pat);
    end else if (p > 1374) begin
    end else if (p == 1365) begin
      exp_m[2047] ^= 8'(pat >> 4);
      exp_m[2048 + 0] ^= 8'((pat & 15) << 4);
    end else if (p > 1365) begin
      b = 3 * p / 2 - 2048;
      if (p % 2 == 1) begin
        exp_m[2048 + b]     ^= 8'(pat >> 4);
        exp_m[2048 + b + 1] ^= 8'((pat & 15) << 4);
      end else begin
        exp_m[2048 + b - 1] ^= 8'(pat >> 8);
        exp_m[2048 + b]     ^= 8'(pat & 255);
      end
    end else if (p % 2 == 1) begin
      exp_m[3 * p / 2]     ^= 8'(pat >> 4);
      exp_m[3 * p / 2 + 1] ^= 8'((pat & 15) << 4);
    end else begin
      exp_m[3 * p / 2 - 1] ^= 8'(pat >> 8);
      exp_m[3 * p / 2]     ^= 8'(pat & 255);
    end
  endtask

  task automatic model_batch(input int cnt, input logic [43:0] pv, input logic [47:0] tv);
    int n;
    n = (cnt > 4) ? 4 : cnt;
    for (int i = 0; i < n; i++) model_pair(int'(pv[i*11 +: 11]), int'(tv[i*12 +: 12]));
  endtask

  task automatic wait_done(output bit seen);
    seen = 1'b0;
    for (int c = 0; c < 200; c++) begin
      @(negedge clk);
      if (done) begin
        seen = 1'b1;
        break;
      end
    end
  endtask

  task automatic check_mem(input string tag);
    int bad, first;
    bad = 0; first = -1;
    for (int a = 0; a < MEMSZ; a++)
      if (ram[a] !== exp_m[a]) begin
        bad++;
        if (first < 0) first = a;
      end
    if (bad == 0) chk(1'b1, tag, 0, 0);
    else chk(1'b0, tag, int'(ram[first]), int'(exp_m[first]));
  endtask

  initial begin
    bit seen;
    for (int a = 0; a < MEMSZ; a++) begin
      ram[a]   = 8'((a * 7) ^ 8'h5A);
      exp_m[a] = 8'((a * 7) ^ 8'h5A);
    end
    repeat (3) @(negedge clk);
    // R10 reset state
    chk(busy == 1'b0, "R10 busy", int'(busy), 0);
    chk(done == 1'b0, "R10 done", int'(done), 0);
    chk(fix_count == 3'd0, "R10 fix_count", int'(fix_count), 0);
    chk(uncorrectable == 1'b0, "R10 flag", int'(uncorrectable), 0);
    chk(touches == 0, "R10 no access", touches, 0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int v = 0; v < NV; v++) begin
      model_batch(int'(V_CNT[v]), V_POS[v], V_PAT[v]);
      pair_cnt = V_CNT[v]; pos_in = V_POS[v]; pat_in = V_PAT[v];
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      wait_done(seen);
      chk(seen, "R8 done seen", int'(seen), 1);
      chk(fix_count == V_EC[v], "R8 fix_count", int'(fix_count), int'(V_EC[v]));
      chk(uncorrectable == V_EE[v], "R8 flag", int'(uncorrectable), int'(V_EE[v]));
      @(negedge clk);
      chk(done == 1'b0, "R8 done width", int'(done), 0);
      check_mem("buffer (R1 R2 R3 R4 R5 R7)");
    end

    // R9: second start during a batch is dropped
    model_batch(1, {11'd0, 11'd0, 11'd0, 11'd20}, {12'h0, 12'h0, 12'h0, 12'h5A5});
    pair_cnt = 3'd1; pos_in = {11'd0, 11'd0, 11'd0, 11'd20};
    pat_in = {12'h0, 12'h0, 12'h0, 12'h5A5};
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    @(negedge clk);
    chk(busy == 1'b1, "R9 busy", int'(busy), 1);
    pair_cnt = 3'd4; pos_in = {11'd33, 11'd32, 11'd31, 11'd30};
    pat_in = {12'hFFF, 12'hFFF, 12'hFFF, 12'hFFF};
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    wait_done(seen);
    chk(seen && fix_count == 3'd1, "R9 count", int'(fix_count), 1);
    repeat (3) @(negedge clk);
    chk(busy == 1'b0, "R9 idle after", int'(busy), 0);
    check_mem("R9 buffer");

    chk(proto_bad == 0, "R6 read-then-write", proto_bad, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #500000;
    errors++; checks++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule